// File: doc/BRIEF.md
# Shared Interrupt Router

This block gathers a group of shared interrupt sources and delivers each one to one or more cores of a multi-core cluster. Every source passes through a programmable polarity stage and a level or edge trigger stage and ends up in a pending bit. The pending bit only counts once the source's enable mask bit is set. A per-source map names the pin the source drives, or marks the source as non-maskable, and a per-source core bitmask picks the cores that receive it.

Software programs the block through a simple word-wide register port with separate write and read strobes. Read data appears one cycle after the read strobe. A single wedge register lets software set or clear a source's pending bit, which serves inter-processor signalling. Each core receives one of two output forms. The raw form is a vector with one bit per pin. The encoded form, meant for an external vectoring controller, gives the pin number of the lowest-indexed qualifying source plus one, so that zero means nothing is pending.

Top module: `shared_irq_router`

## Requirements
- R1: Word 0x00 is read-only and reads `(NUM_SRC/8-1)` in bits [15:8] and `(NUM_CORE-1)` in bits [3:0], with all other bits zero. The default configuration reads 0x00000303.
- R2: After reset, the polarity word (0x02) reads all ones (active high), the trigger word (0x03) reads zero (level), the mask word (0x04) and the pending word (0x07) read zero, the mode is raw, and all outputs are low.
- R3: A level source (trigger bit 0) is pending exactly while its input equals its polarity bit. Polarity bit 1 means active high and 0 means active low.
- R4: An edge source (trigger bit 1) becomes pending when its polarity-adjusted input rises. It stays pending after the input drops, until a wedge write with bit 31 clear names it.
- R5: A write to the wedge word 0x08 with bit 31 set makes the source whose index is in bits [4:0] pending. With bit 31 clear, the same write clears that source's latched pending state.
- R6: A write of index k to 0x05 sets mask bit k, and a write of index k to 0x06 clears mask bit k. No other mask bit changes.
- R7: In raw mode, output bit `core*8+pin` of `core_pins` is high only when some source is pending, has its mask bit set, has its core bit set in its core map (0x80+i), and has its map word (0x40+i) with bit 31 set and the pin in bits [2:0].
- R8: A source whose map word has bit 30 set drives `core_nmi` of every core whose bit is set in its core map, provided it is pending and enabled. Such a source drives no pin output.
- R9: When bit 0 of the mode word 0x01 is 1, `core_vec[core*4+:4]` equals the pin of the lowest-indexed qualifying source plus one, or 0 when none qualifies, and `core_pins` stays zero. In raw mode `core_vec` stays zero.
- R10: If a wedge clear and a fresh active edge reach the same source in the same cycle, the edge wins and the source stays pending.
- R11: The pending word (0x07) and the mask word (0x04) each read with bit i reflecting source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| src_in | input | NUM_SRC | Raw interrupt source inputs |
| core_pins | output | NUM_CORE*8 | Raw-mode pin vector per core |
| core_vec | output | NUM_CORE*4 | Encoded-mode pin-plus-one per core |
| core_nmi | output | NUM_CORE | Non-maskable request per core |

## Verification
The clash that matters is a software wedge clear for an edge source landing in the very cycle in which the same source's input edge is recognised. The bench first raises the source input. On the next cycle it issues the wedge clear, so that the write and the rising edge reach the pending latch at the same clock edge. It then reads the pending word. The source must still be pending, and a second clear with the input held low must leave it idle.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

  localparam logic [7:0] ADR_CFG     = 8'h00;
  localparam logic [7:0] ADR_MODE    = 8'h01;
  localparam logic [7:0] ADR_POL     = 8'h02;
  localparam logic [7:0] ADR_TRIG    = 8'h03;
  localparam logic [7:0] ADR_MASK    = 8'h04;
  localparam logic [7:0] ADR_MSET    = 8'h05;
  localparam logic [7:0] ADR_MCLR    = 8'h06;
  localparam logic [7:0] ADR_PEND    = 8'h07;
  localparam logic [7:0] ADR_WEDGE   = 8'h08;
  localparam logic [7:0] ADR_PINMAP  = 8'h40;
  localparam logic [7:0] ADR_COREMAP = 8'h80;

  localparam int BIT_ROUTE_EN = 31;
  localparam int BIT_NMI      = 30;
  localparam int BIT_WSET     = 31;

  // Encoded size word: sources in groups of eight, cores minus one.
  function automatic logic [31:0] cfg_word(input int nsrc, input int ncore);
    logic [31:0] w;
    w        = '0;
    w[15:8]  = 8'(nsrc / 8 - 1);
    w[3:0]   = 4'(ncore - 1);
    return w;
  endfunction

endpackage

// File: rtl/sir_regs.sv
module sir_regs
  import shared_irq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int PIN_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [7:0]                         wr_addr,
  input  logic [31:0]                        wr_data,
  input  logic                               rd_en,
  input  logic [7:0]                         rd_addr,
  output logic [31:0]                        rd_data,
  input  logic [NUM_SRC-1:0]                 pend_vec,
  output logic                               mode_q,
  output logic [NUM_SRC-1:0]                 pol_q,
  output logic [NUM_SRC-1:0]                 trig_q,
  output logic [NUM_SRC-1:0]                 mask_q,
  output logic [NUM_SRC-1:0]                 pin_en_q,
  output logic [NUM_SRC-1:0]                 pin_nmi_q,
  output logic [NUM_SRC-1:0][PIN_W-1:0]      pin_num_q,
  output logic [NUM_SRC-1:0][NUM_CORE-1:0]   route_q,
  output logic [NUM_SRC-1:0]                 wset_vec,
  output logic [NUM_SRC-1:0]                 wclr_vec
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [IDX_W-1:0]   wr_idx;
  logic [NUM_SRC-1:0] idx_onehot;
  logic               hit_mset, hit_mclr, hit_wedge;
  logic [31:0]        rd_next;

  assign wr_idx     = wr_data[IDX_W-1:0];
  assign idx_onehot = NUM_SRC'(1) << wr_idx;
  assign hit_mset   = wr_en && (wr_addr == ADR_MSET);
  assign hit_mclr   = wr_en && (wr_addr == ADR_MCLR);
  assign hit_wedge  = wr_en && (wr_addr == ADR_WEDGE);

  // Wedge decode: one source per write, bit 31 selects set or clear.
  assign wset_vec = (hit_wedge &&  wr_data[BIT_WSET]) ? idx_onehot : '0;
  assign wclr_vec = (hit_wedge && !wr_data[BIT_WSET]) ? idx_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pol_q  <= '1;
      trig_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_MODE) mode_q <= wr_data[0];
      if (wr_en && wr_addr == ADR_POL)  pol_q  <= wr_data[NUM_SRC-1:0];
      if (wr_en && wr_addr == ADR_TRIG) trig_q <= wr_data[NUM_SRC-1:0];
      if (hit_mset) mask_q <= mask_q | idx_onehot;
      if (hit_mclr) mask_q <= mask_q & ~idx_onehot;
    end
  end

  // Per-source map and routing words.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    logic hit_pin, hit_core;
    assign hit_pin  = wr_en && (wr_addr == ADR_PINMAP  + 8'(s));
    assign hit_core = wr_en && (wr_addr == ADR_COREMAP + 8'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_en_q[s]  <= 1'b0;
        pin_nmi_q[s] <= 1'b0;
        pin_num_q[s] <= '0;
        route_q[s]   <= '0;
      end else begin
        if (hit_pin) begin
          pin_en_q[s]  <= wr_data[BIT_ROUTE_EN];
          pin_nmi_q[s] <= wr_data[BIT_NMI];
          pin_num_q[s] <= wr_data[PIN_W-1:0];
        end
        if (hit_core) route_q[s] <= wr_data[NUM_CORE-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADR_CFG:  rd_next = cfg_word(NUM_SRC, NUM_CORE);
      ADR_MODE: rd_next = {31'b0, mode_q};
      ADR_POL:  rd_next = 32'(pol_q);
      ADR_TRIG: rd_next = 32'(trig_q);
      ADR_MASK: rd_next = 32'(mask_q);
      ADR_PEND: rd_next = 32'(pend_vec);
      default: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (rd_addr == ADR_PINMAP + 8'(s))
            rd_next = {pin_en_q[s], pin_nmi_q[s], {(30-PIN_W){1'b0}}, pin_num_q[s]};
          if (rd_addr == ADR_COREMAP + 8'(s))
            rd_next = {{(32-NUM_CORE){1'b0}}, route_q[s]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/sir_pend.sv
module sir_pend #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] trig,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] rise_vec
);

  logic [NUM_SRC-1:0] in_q, adj, adj_q;

  // Polarity bit 1 passes the input, 0 inverts it.
  function automatic logic [NUM_SRC-1:0] apply_pol(input logic [NUM_SRC-1:0] raw,
                                                   input logic [NUM_SRC-1:0] p);
    return raw ^ ~p;
  endfunction

  // Latch update: a clear is overridden by a same-cycle edge or set.
  function automatic logic [NUM_SRC-1:0] next_latch(input logic [NUM_SRC-1:0] cur,
                                                    input logic [NUM_SRC-1:0] edg,
                                                    input logic [NUM_SRC-1:0] st,
                                                    input logic [NUM_SRC-1:0] cl);
    return (cur & ~cl) | edg | st;
  endfunction

  assign adj      = apply_pol(in_q, pol);
  assign rise_vec = trig & adj & ~adj_q;
  assign pend_vec = latch_q | (~trig & adj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      adj_q   <= '0;
      latch_q <= '0;
    end else begin
      in_q    <= src_in;
      adj_q   <= adj;
      latch_q <= next_latch(latch_q, rise_vec, set_vec, clr_vec);
    end
  end

endmodule

// File: rtl/sir_route.sv
module sir_route #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int PIN_W    = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   enc_mode,
  input  logic [NUM_SRC-1:0]                     pend_vec,
  input  logic [NUM_SRC-1:0]                     mask_q,
  input  logic [NUM_SRC-1:0]                     pin_en_q,
  input  logic [NUM_SRC-1:0]                     pin_nmi_q,
  input  logic [NUM_SRC-1:0][PIN_W-1:0]          pin_num_q,
  input  logic [NUM_SRC-1:0][NUM_CORE-1:0]       route_q,
  output logic [NUM_CORE-1:0][(1<<PIN_W)-1:0]    pins_out,
  output logic [NUM_CORE-1:0][PIN_W:0]           vec_out,
  output logic [NUM_CORE-1:0]                    nmi_out
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int NPIN  = 1 << PIN_W;
  localparam int VEC_W = PIN_W + 1;

  // Lowest set bit: {found, index}.
  function automatic logic [IDX_W:0] lowest(input logic [NUM_SRC-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  // Zero means idle, so the pin number is shifted up by one.
  function automatic logic [VEC_W-1:0] encode_pin(input logic found,
                                                  input logic [PIN_W-1:0] pin);
    return found ? (VEC_W'(pin) + VEC_W'(1)) : '0;
  endfunction

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] live, qual_pin, qual_nmi;
    logic [NPIN-1:0]    pins_n, pins_r;
    logic [IDX_W:0]     pick;
    logic [VEC_W-1:0]   vec_n, vec_r;
    logic               nmi_r;

    always_comb begin
      for (int s = 0; s < NUM_SRC; s++)
        live[s] = pend_vec[s] & mask_q[s] & route_q[s][c];
    end

    assign qual_pin = live & pin_en_q & ~pin_nmi_q;
    assign qual_nmi = live & pin_nmi_q;

    always_comb begin
      pins_n = '0;
      for (int s = 0; s < NUM_SRC; s++)
        if (qual_pin[s]) pins_n = pins_n | (NPIN'(1) << pin_num_q[s]);
    end

    assign pick  = lowest(qual_pin);
    assign vec_n = encode_pin(pick[IDX_W], pin_num_q[pick[IDX_W-1:0]]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pins_r <= '0;
        vec_r  <= '0;
        nmi_r  <= 1'b0;
      end else begin
        pins_r <= enc_mode ? '0 : pins_n;
        vec_r  <= enc_mode ? vec_n : '0;
        nmi_r  <= |qual_nmi;
      end
    end

    assign pins_out[c] = pins_r;
    assign vec_out[c]  = vec_r;
    assign nmi_out[c]  = nmi_r;
  end

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int PIN_W    = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [7:0]                           wr_addr,
  input  logic [31:0]                          wr_data,
  input  logic                                 rd_en,
  input  logic [7:0]                           rd_addr,
  output logic [31:0]                          rd_data,
  input  logic [NUM_SRC-1:0]                   src_in,
  output logic [NUM_CORE*(1<<PIN_W)-1:0]       core_pins,
  output logic [NUM_CORE*(PIN_W+1)-1:0]        core_vec,
  output logic [NUM_CORE-1:0]                  core_nmi
);

  localparam int NPIN = 1 << PIN_W;

  logic                               mode_q;
  logic [NUM_SRC-1:0]                 pol_q, trig_q, mask_q;
  logic [NUM_SRC-1:0]                 pin_en_q, pin_nmi_q;
  logic [NUM_SRC-1:0][PIN_W-1:0]      pin_num_q;
  logic [NUM_SRC-1:0][NUM_CORE-1:0]   route_q;
  logic [NUM_SRC-1:0]                 wset_vec, wclr_vec;
  logic [NUM_SRC-1:0]                 pend_vec, latch_q, rise_vec;
  logic [NUM_CORE-1:0][NPIN-1:0]      pins_2d;
  logic [NUM_CORE-1:0][PIN_W:0]       vec_2d;

  sir_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pend_vec(pend_vec),
    .mode_q(mode_q), .pol_q(pol_q), .trig_q(trig_q), .mask_q(mask_q),
    .pin_en_q(pin_en_q), .pin_nmi_q(pin_nmi_q), .pin_num_q(pin_num_q),
    .route_q(route_q), .wset_vec(wset_vec), .wclr_vec(wclr_vec)
  );

  sir_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .pol(pol_q), .trig(trig_q), .set_vec(wset_vec), .clr_vec(wclr_vec),
    .pend_vec(pend_vec), .latch_q(latch_q), .rise_vec(rise_vec)
  );

  sir_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)) u_route (
    .clk(clk), .rst_n(rst_n), .enc_mode(mode_q),
    .pend_vec(pend_vec), .mask_q(mask_q),
    .pin_en_q(pin_en_q), .pin_nmi_q(pin_nmi_q), .pin_num_q(pin_num_q),
    .route_q(route_q),
    .pins_out(pins_2d), .vec_out(vec_2d), .nmi_out(core_nmi)
  );

  assign core_pins = pins_2d;
  assign core_vec  = vec_2d;

endmodule

// File: rtl/shared_irq_router_chk.sv
module shared_irq_router_chk
  import shared_irq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int PIN_W    = 3
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               wr_en,
  input logic [7:0]                         wr_addr,
  input logic                               wr_flag,
  input logic [$clog2(NUM_SRC)-1:0]         wr_idx,
  input logic                               mode_q,
  input logic [NUM_SRC-1:0]                 mask_q,
  input logic [NUM_SRC-1:0]                 pend_vec,
  input logic [NUM_SRC-1:0]                 latch_q,
  input logic [NUM_SRC-1:0]                 clr_vec,
  input logic [NUM_CORE*(1<<PIN_W)-1:0]     core_pins,
  input logic [NUM_CORE*(PIN_W+1)-1:0]      core_vec,
  input logic [NUM_CORE-1:0]                core_nmi
);

  localparam int VEC_W = PIN_W + 1;
  localparam int NPIN  = 1 << PIN_W;

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '0 && core_pins == '0 && core_vec == '0 && core_nmi == '0));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_MSET) |=> mask_q[$past(wr_idx)]);

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_MCLR) |=> !mask_q[$past(wr_idx)]);

  assert_wedge_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_WEDGE && wr_flag) |=> pend_vec[$past(wr_idx)]);

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & $past(latch_q & ~clr_vec)) == $past(latch_q & ~clr_vec)));

  assert_enc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) |-> (core_pins == '0));

  assert_raw_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_q) |-> (core_vec == '0));

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_vec
    assert_vec_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_vec[c*VEC_W +: VEC_W] <= VEC_W'(NPIN));
  end

endmodule

bind shared_irq_router shared_irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_flag(wr_data[31]), .wr_idx(wr_data[$clog2(NUM_SRC)-1:0]),
  .mode_q(mode_q), .mask_q(mask_q), .pend_vec(pend_vec),
  .latch_q(latch_q), .clr_vec(wclr_vec),
  .core_pins(core_pins), .core_vec(core_vec), .core_nmi(core_nmi)
);

// File: tb/test_shared_irq_router.sv
module test_shared_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] src_in = '0;
  logic [31:0] core_pins;
  logic [15:0] core_vec;
  logic [3:0]  core_nmi;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  shared_irq_router i_shared_irq_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .src_in(src_in),
    .core_pins(core_pins), .core_vec(core_vec), .core_nmi(core_nmi)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    bus_rd(8'h00, rv); chk("R1 cfg", rv, 32'h0000_0303);
    bus_rd(8'h02, rv); chk("R2 pol", rv, 32'hFFFF_FFFF);
    bus_rd(8'h03, rv); chk("R2 trig", rv, 32'h0);
    bus_rd(8'h04, rv); chk("R2 mask", rv, 32'h0);
    bus_rd(8'h07, rv); chk("R2 pend", rv, 32'h0);
    chk("R2 outputs", {core_pins}, 32'h0);
    chk("R2 vec/nmi", {12'h0, core_vec, core_nmi}, 32'h0);
  endtask

  task automatic t_level();
    bus_wr(8'h45, 32'h8000_0002);
    bus_wr(8'h85, 32'h2);
    bus_wr(8'h05, 32'd5);
    src_in[5] = 1'b1; settle();
    chk("R3 level high", core_pins, 32'h1 << 10);
    bus_rd(8'h07, rv); chk("R11 pend word", rv, 32'h1 << 5);
    src_in[5] = 1'b0; settle();
    chk("R3 level low", core_pins, 32'h0);
    bus_wr(8'h02, ~(32'h1 << 5)); settle();
    chk("R3 active low asserted", core_pins, 32'h1 << 10);
    src_in[5] = 1'b1; settle();
    chk("R3 active low idle", core_pins, 32'h0);
    src_in[5] = 1'b0;
    bus_wr(8'h02, 32'hFFFF_FFFF); settle();
  endtask

  task automatic t_gate();
    src_in[5] = 1'b1; settle();
    chk("R7 qualified", core_pins, 32'h1 << 10);
    bus_wr(8'h06, 32'd5); settle();
    chk("R7 masked", core_pins, 32'h0);
    bus_rd(8'h04, rv); chk("R11 mask word", rv, 32'h0);
    bus_wr(8'h05, 32'd5);
    bus_wr(8'h85, 32'h0); settle();
    chk("R7 no core route", core_pins, 32'h0);
    bus_wr(8'h85, 32'h2);
    bus_wr(8'h45, 32'h0000_0002); settle();
    chk("R7 pin disabled", core_pins, 32'h0);
    src_in[5] = 1'b0;
    bus_wr(8'h06, 32'd5);
  endtask

  task automatic t_mask_ops();
    bus_wr(8'h05, 32'd1);
    bus_wr(8'h05, 32'd2);
    bus_wr(8'h05, 32'd31);
    bus_rd(8'h04, rv); chk("R6 set three", rv, 32'h8000_0006);
    bus_wr(8'h06, 32'd1);
    bus_rd(8'h04, rv); chk("R6 clear one", rv, 32'h8000_0004);
    bus_wr(8'h06, 32'd2);
    bus_wr(8'h06, 32'd31);
    bus_rd(8'h04, rv); chk("R6 all clear", rv, 32'h0);
  endtask

  task automatic t_edge();
    bus_wr(8'h03, 32'h1 << 9);
    bus_wr(8'h49, 32'h8000_0007);
    bus_wr(8'h89, 32'h1);
    bus_wr(8'h05, 32'd9);
    @(negedge clk); src_in[9] = 1'b1;
    @(negedge clk); src_in[9] = 1'b0;
    settle();
    chk("R4 edge latched", core_pins, 32'h1 << 7);
    bus_rd(8'h07, rv); chk("R4 edge held", rv, 32'h1 << 9);
    bus_wr(8'h08, 32'd9); settle();
    chk("R4 cleared by wedge", core_pins, 32'h0);
    bus_rd(8'h07, rv); chk("R4 pend gone", rv, 32'h0);
  endtask

  task automatic t_race();
    @(negedge clk); src_in[9] = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'd9;
    @(negedge clk); wr_en = 1'b0; src_in[9] = 1'b0;
    settle();
    bus_rd(8'h07, rv); chk("R10 edge beats clear", rv, 32'h1 << 9);
    bus_wr(8'h08, 32'd9); settle();
    bus_rd(8'h07, rv); chk("R10 later clear", rv, 32'h0);
    bus_wr(8'h06, 32'd9);
    bus_wr(8'h03, 32'h0);
  endtask

  task automatic t_wedge();
    bus_wr(8'h54, 32'h8000_0004);
    bus_wr(8'h94, 32'h8);
    bus_wr(8'h05, 32'd20);
    bus_wr(8'h08, 32'h8000_0014); settle();
    chk("R5 wedge set pin", core_pins, 32'h1 << 28);
    bus_rd(8'h07, rv); chk("R5 wedge pend", rv, 32'h1 << 20);
    bus_wr(8'h08, 32'h0000_0014); settle();
    chk("R5 wedge clear", core_pins, 32'h0);
    bus_wr(8'h06, 32'd20);
  endtask

  task automatic t_nmi();
    bus_wr(8'h4C, 32'h4000_0000);
    bus_wr(8'h8C, 32'hF);
    bus_wr(8'h05, 32'd12);
    bus_wr(8'h08, 32'h8000_000C); settle();
    chk("R8 nmi all cores", {28'h0, core_nmi}, 32'hF);
    chk("R8 no pins", core_pins, 32'h0);
    bus_wr(8'h8C, 32'h5); settle();
    chk("R8 nmi subset", {28'h0, core_nmi}, 32'h5);
    bus_wr(8'h08, 32'h0000_000C); settle();
    chk("R8 nmi idle", {28'h0, core_nmi}, 32'h0);
    bus_wr(8'h06, 32'd12);
  endtask

  task automatic t_enc();
    bus_wr(8'h01, 32'h1);
    bus_wr(8'h43, 32'h8000_0005); bus_wr(8'h83, 32'h4);
    bus_wr(8'h4A, 32'h8000_0001); bus_wr(8'h8A, 32'h4);
    bus_wr(8'h05, 32'd3); bus_wr(8'h05, 32'd10);
    settle();
    chk("R9 idle zero", {16'h0, core_vec}, 32'h0);
    bus_wr(8'h08, 32'h8000_000A); settle();
    chk("R9 single", {16'h0, core_vec}, 32'h0000_0200);
    bus_wr(8'h08, 32'h8000_0003); settle();
    chk("R9 lowest wins", {16'h0, core_vec}, 32'h0000_0600);
    chk("R9 pins quiet", core_pins, 32'h0);
    bus_wr(8'h08, 32'h0000_0003);
    bus_wr(8'h4A, 32'h8000_0007); settle();
    chk("R9 top pin", {16'h0, core_vec}, 32'h0000_0800);
    bus_wr(8'h08, 32'h0000_000A); settle();
    chk("R9 back to zero", {16'h0, core_vec}, 32'h0);
    bus_wr(8'h01, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_gate();
    t_mask_ops();
    t_edge();
    t_race();
    t_wedge();
    t_nmi();
    t_enc();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule